// File: doc/BRIEF.md
# Sequential Two-Digit LED Display Driver

This block presents a number between 0 and 99 on one seven-segment digit with a decimal point. It does this over time. It splits the stored number into a tens digit and a ones digit. It shows the tens digit with the point dark, then the ones digit with the point lit, and repeats. The point tells a viewer which half of the number is on show. A prescaler sets the length of each display phase. In a real system it is set so the digit changes about every two seconds, which is an alternation rate of roughly 0.5 Hz.

A producer offers a new number with a one-cycle strobe. The block keeps the most recent offer in a pending register. That value moves into the displayed register only when a new tens phase begins, so the two digits shown always come from the same number. A debug select field can bypass the decimal decoder and put internal values straight onto the eight output pins, for fast observation on a logic analyser.

Top module: `seq_digit_display`

## Requirements
- R1: While reset is asserted (rst_n low), the block clears the pending and displayed values and starts in the tens phase. With dbg_sel_i = 0 the output then reads 8'h3F, and with dbg_sel_i = 1 it reads 8'h00.
- R2: In the tens phase with dbg_sel_i = 0, seg_o[6:0] drives the tens digit of the displayed value and seg_o[7] is 0. The encoding is active-high, with bit 0 for segment a through bit 6 for segment g. The digit codes are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R3: In the ones phase with dbg_sel_i = 0, seg_o[6:0] drives the ones digit in the same encoding and seg_o[7] is 1.
- R4: Each phase lasts exactly PHASE_TICKS clock cycles, and the tens and ones phases strictly alternate.
- R5: A strobed value becomes the displayed value only at the transition from the ones phase to the tens phase. A strobe taken in any other cycle leaves the digits of the current pair unchanged.
- R6: If a strobe falls in the same cycle as the ones-to-tens transition, the newly strobed value is the one displayed in the pair that starts.
- R7: A displayed value above 99 blanks both digits (seg_o[6:0] = 0), while the point still follows the phase.
- R8: With dbg_sel_i = 1, seg_o carries the binary value of the latest strobe, one cycle after the strobe.
- R9: With dbg_sel_i = 2, seg_o carries the displayed value as packed BCD, with the tens in [7:4] and the ones in [3:0]. A value above 99 reads 8'hFF.
- R10: Any other non-zero dbg_sel_i drives seg_o to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| value_i | input | VAL_W | Number offered for display |
| value_stb_i | input | 1 | One-cycle strobe that loads value_i into the pending register |
| dbg_sel_i | input | 3 | Output select: 0 normal, 1 raw pending value, 2 BCD of displayed value, others zero |
| seg_o | output | 8 | Segments a..g on bits 0..6, decimal point on bit 7 |

## Verification
Two functions can land in the same cycle: a producer strobe and the phase wrap that copies the pending value into the display. The bench locks onto the wrap by watching the decimal point fall. It then counts 2·PHASE_TICKS−1 cycles and raises the strobe so that it lands exactly on the next wrap edge. It judges the result by requiring that the newly strobed number's tens digit appears at once. A second case strobes just after a wrap and checks that the digits of the pair on show do not change until the following wrap.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  typedef enum logic {
    PH_TENS = 1'b0,
    PH_ONES = 1'b1
  } phase_e;

  typedef enum logic [2:0] {
    DBG_OFF = 3'd0,
    DBG_RAW = 3'd1,
    DBG_BCD = 3'd2
  } dbg_e;

  localparam logic [3:0] DIG_BLANK = 4'hF;

  // active-high segments, bit0 = a .. bit6 = g; non-decimal codes blank
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sdd_prescaler.sv
module sdd_prescaler #(
  parameter int unsigned PHASE_TICKS = 25_000_000,
  localparam int unsigned CNT_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            tick_o,
  output sdd_pkg::phase_e phase_o
);
  import sdd_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           ph_q, ph_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    ph_d   = ph_q;
    if (tick_o) ph_d = (ph_q == PH_TENS) ? PH_ONES : PH_TENS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_TENS;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase_o = ph_q;

  // R4: a phase flip only ever follows a full count
  assert_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> ($past(cnt_q) == LAST));

  // R4: counter never passes its terminal value
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sdd_dec_split.sv
module sdd_dec_split #(
  parameter int unsigned VAL_W = 8
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [3:0]       tens_o,
  output logic [3:0]       ones_o
);
  import sdd_pkg::*;

  logic [3:0] tens_raw;

  // divide by ten via a ladder of constant compares, valid for 0..99
  always_comb begin
    tens_raw = 4'd0;
    for (int i = 1; i <= 9; i++) begin
      if (val_i >= VAL_W'(10 * i)) tens_raw = 4'(i);
    end
  end

  always_comb begin
    if (val_i > VAL_W'(99)) begin
      tens_o = DIG_BLANK;
      ones_o = DIG_BLANK;
    end else begin
      tens_o = tens_raw;
      ones_o = 4'(val_i - VAL_W'(tens_raw) * VAL_W'(10));
    end
  end

  // R2: digits recombine to the input for every in-range value
  always_comb begin
    if (!$isunknown(val_i) && val_i <= VAL_W'(99)) begin
      assert_split_R2: assert (tens_o <= 4'd9 && ones_o <= 4'd9 &&
        (VAL_W'(tens_o) * VAL_W'(10) + VAL_W'(ones_o)) == val_i);
    end
  end

endmodule

// File: rtl/seq_digit_display.sv
module seq_digit_display #(
  parameter int unsigned PHASE_TICKS = 25_000_000,
  parameter int unsigned VAL_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] value_i,
  input  logic             value_stb_i,
  input  logic [2:0]       dbg_sel_i,
  output logic [7:0]       seg_o
);
  import sdd_pkg::*;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic   tick;
  phase_e phase;
  logic   wrap;

  sdd_prescaler #(.PHASE_TICKS(PHASE_TICKS)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_o  (tick),
    .phase_o (phase)
  );

  assign wrap = tick && (phase == PH_ONES);

  logic [VAL_W-1:0] pend_q, pend_d;
  logic [VAL_W-1:0] shown_q, shown_d;

  always_comb begin
    pend_d  = value_stb_i ? value_i : pend_q;
    shown_d = wrap ? pend_d : shown_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q  <= '0;
      shown_q <= '0;
    end else begin
      pend_q  <= pend_d;
      shown_q <= shown_d;
    end
  end

  logic [3:0] tens, ones;

  sdd_dec_split #(.VAL_W(VAL_W)) u_split (
    .val_i  (shown_q),
    .tens_o (tens),
    .ones_o (ones)
  );

  logic [3:0] digit;
  logic [7:0] seg_norm;

  always_comb begin
    digit    = (phase == PH_TENS) ? tens : ones;
    seg_norm = {phase == PH_ONES, seg_of(digit)};
    case (dbg_e'(dbg_sel_i))
      DBG_OFF: seg_o = seg_norm;
      DBG_RAW: seg_o = 8'(pend_q);
      DBG_BCD: seg_o = {tens, ones};
      default: seg_o = 8'h00;
    endcase
  end

  // R5: displayed value moves only on a ones-to-tens wrap
  assert_capture_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shown_q != $past(shown_q)) |-> $past(wrap));

  // R6: strobe coincident with wrap is forwarded into the display
  assert_stb_forward_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wrap && value_stb_i) |=> (shown_q == $past(value_i)));

  // R5: in normal mode the pins hold still within a phase of one value
  assert_seg_steady_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dbg_sel_i == 3'd0 && $past(dbg_sel_i) == 3'd0 && phase == $past(phase) &&
     shown_q == $past(shown_q)) |-> $stable(seg_o));

  // R8: raw debug view shows the value of the previous strobe
  assert_raw_view_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dbg_sel_i == 3'd1 && $past(value_stb_i)) |-> (seg_o == 8'($past(value_i))));

endmodule

// File: tb/tb_seq_digit_display.sv
module tb_seq_digit_display;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 6;
  localparam int GUARD      = 8 * P + 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] value_i;
  logic       value_stb_i;
  logic [2:0] dbg_sel_i;
  logic [7:0] seg_o;

  int checks = 0;
  int errors = 0;

  seq_digit_display #(.PHASE_TICKS(P), .VAL_W(8)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .value_i     (value_i),
    .value_stb_i (value_stb_i),
    .dbg_sel_i   (dbg_sel_i),
    .seg_o       (seg_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {value, tens-phase pins, ones-phase pins}
  localparam logic [23:0] VEC [8] = '{
    {8'd0,   8'h3F, 8'hBF},
    {8'd7,   8'h3F, 8'h87},
    {8'd10,  8'h06, 8'hBF},
    {8'd42,  8'h66, 8'hDB},
    {8'd63,  8'h7D, 8'hCF},
    {8'd98,  8'h6F, 8'hFF},
    {8'd99,  8'h6F, 8'hEF},
    {8'd150, 8'h00, 8'h80}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] v);
    value_i     = v;
    value_stb_i = 1'b1;
    step();
    value_stb_i = 1'b0;
  endtask

  // returns at the first negedge of a fresh tens phase
  task automatic wait_tens_start();
    int g = 0;
    while (seg_o[7] !== 1'b1 && g < GUARD) begin step(); g++; end
    while (seg_o[7] !== 1'b0 && g < GUARD) begin step(); g++; end
    if (g >= GUARD) begin
      checks++; errors++;
      $display("FAIL R4 phase sequence stalled got %0d expected <%0d", g, GUARD);
    end
  endtask

  // steps until the point lights, returning the number of cycles taken
  task automatic wait_ones(output int n);
    n = 0;
    while (seg_o[7] !== 1'b1 && n < GUARD) begin step(); n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n       = 1'b0;
    value_i     = '0;
    value_stb_i = 1'b0;
    dbg_sel_i   = 3'd0;
    step(); step();
    chk("R1 reset pins", seg_o, 8'h3F);
    rst_n = 1'b1;

    // table walk: R2 tens, R3 ones, R4 phase length, R7 out of range
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][23:16]);
      wait_tens_start();
      chk((VEC[i][23:16] > 99) ? "R7 tens blank" : "R2 tens digit", seg_o, VEC[i][15:8]);
      wait_ones(n);
      chk("R4 phase length", 8'(n), 8'(P));
      chk((VEC[i][23:16] > 99) ? "R7 ones blank" : "R3 ones digit", seg_o, VEC[i][7:0]);
    end

    // R5: strobe mid-pair does not disturb the pair on show
    strobe(8'd42);
    wait_tens_start();
    strobe(8'd7);
    step();
    chk("R5 tens held", seg_o, 8'h66);
    wait_ones(n);
    chk("R5 ones held", seg_o, 8'hDB);
    wait_tens_start();
    chk("R5 new value at wrap", seg_o, 8'h3F);
    wait_ones(n);
    chk("R5 new ones", seg_o, 8'h87);
    wait_tens_start();

    // R6: strobe lands on the wrap edge itself
    repeat (2 * P - 1) step();
    strobe(8'd63);
    chk("R6 forwarded tens", seg_o, 8'h7D);

    // R9, R10, R8 debug views
    dbg_sel_i = 3'd2; step();
    chk("R9 bcd view", seg_o, 8'h63);
    dbg_sel_i = 3'd5; step();
    chk("R10 other select", seg_o, 8'h00);
    dbg_sel_i = 3'd1;
    strobe(8'hA5);
    chk("R8 raw view", seg_o, 8'hA5);
    strobe(8'h3C);
    chk("R8 raw view update", seg_o, 8'h3C);
    dbg_sel_i = 3'd0;
    wait_tens_start();
    chk("R2 tens of 60", seg_o, 8'h7D);
    strobe(8'd200);
    wait_tens_start();
    chk("R7 tens blank 200", seg_o, 8'h00);
    wait_ones(n);
    chk("R7 ones blank 200", seg_o, 8'h80);
    dbg_sel_i = 3'd2; step();
    chk("R9 bcd over range", seg_o, 8'hFF);

    // R1: reset in the middle of operation
    dbg_sel_i = 3'd0;
    rst_n = 1'b0; step();
    chk("R1 reset mid-run", seg_o, 8'h3F);
    dbg_sel_i = 3'd1; step();
    chk("R1 pending cleared", seg_o, 8'h00);
    dbg_sel_i = 3'd0;
    rst_n = 1'b1;
    wait_tens_start();
    chk("R1 zero after reset", seg_o, 8'h3F);
    wait_ones(n);
    chk("R1 zero ones after reset", seg_o, 8'hBF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule